// File: doc/BRIEF.md
# Ring-Chord Source Header Generator

This block sits in the network interface of a node on a ring network that also has chords. The ring has `NODES` nodes. Each node has a link to the next node clockwise, a link to the previous node, and a chord to the node halfway round. The switches in this network make no routing decisions. A packet's path is fixed entirely by the injection port the source uses, and each header names the last node its branch has to reach. This block makes both of those choices. It takes one send request (unicast, multicast or broadcast) and the node's own address, and loads one header flit into each injection port that the request needs.

There are four injection ports, each with its own valid/ready output handshake: left, cross-left, cross-right and right. A unicast goes out on one port, picked from the destination's offset from the source. A broadcast goes out as four branch packets. A multicast takes an N-bit target mask indexed by absolute node address. The block splits the mask into one hop-ordered bitstring per branch and sends a header only on branches that have at least one target. The branches drain independently. A new request is taken only when all four ports are empty. A request that cannot be sent is dropped, and an error pulse is raised instead.

Top module: `ring_hdr_gen`

## Requirements
- R1: After reset, `hdr_valid` is 0, `req_ready` is 1 and `req_err` is 0.
- R2: `req_ready` is high only when no port holds a header. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its headers, or its error pulse, appear in the cycle that follows that edge.
- R3: A unicast (`req_type` 00) uses offset d = (`req_dest` - `local_addr`) mod N. The port is chosen as follows: d in 1..N/4 → port 0 (left); N/2-N/4+1..N/2 → port 1 (cross-left); N/2+1..N/2+N/4-1 → port 2 (cross-right); N-N/4..N-1 → port 3 (right). Exactly one header is emitted. It carries type 00, destination `req_dest` and a zero bitstring.
- R4: A broadcast (`req_type` 10) loads all four ports. Each header has type 10 and a zero bitstring. The destinations are local+N/4, local+N/2-N/4+1, local+N/2+N/4-1 and local-N/4 (mod N) on ports 0..3. For N=16 and local 0 these are 4, 5, 11 and 12.
- R5: For a multicast (`req_type` 01), bit j of `req_mask` marks absolute node j, and the bit for the local node is ignored. Bit k of a branch bitstring marks the node k+1 hops out on that branch. The offset of that node is k+1 on the left branch, N/2-k on cross-left, N/2+k on cross-right and N-1-k on the right branch. Bit 0 of the cross-right bitstring is always 0.
- R6: A multicast header has type 01 and goes only to ports whose bitstring is nonzero. Its destination is the absolute address of the farthest target on that branch.
- R7: The header on port p is `hdr_flit[p*FW +: FW]`, laid out as {type[1:0], dest[$clog2(N)-1:0], bits[N/4-1:0]}. Type is in the top two bits, and code 11 never appears.
- R8: A loaded header holds its value until its port's ready is seen. A port that stalls does not hold back the other ports.
- R9: Three kinds of request are dropped: a unicast to the local address, a multicast with no target other than the local node, and type 11. For each, `req_err` is high for one cycle and no header is loaded.
- R10: Fields the request type does not use have no effect on the output. `req_mask` is unused for unicast and broadcast, and `req_dest` is unused for multicast and broadcast.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| local_addr | input | $clog2(NODES) | Address of this node |
| req_valid | input | 1 | Send request offered |
| req_ready | output | 1 | All ports empty, request can be taken |
| req_type | input | 2 | 00 unicast, 01 multicast, 10 broadcast, 11 reserved |
| req_dest | input | $clog2(NODES) | Unicast destination address |
| req_mask | input | NODES | Multicast targets by absolute address |
| req_err | output | 1 | One-cycle pulse for a dropped request |
| hdr_valid | output | 4 | Header present per port (0 left, 1 cross-left, 2 cross-right, 3 right) |
| hdr_ready | input | 4 | Downstream accepts the header per port |
| hdr_flit | output | 4*FW | Four header flits, port p at bits p*FW +: FW |

## Verification
The assertions take `local_addr` to be below `NODES`. They also take it to change only while no header is waiting and no request is offered, because a change while a request is in flight would move every offset and branch end under an active request. The bench changes `local_addr` only after every port has drained, in the same cycle it offers the next request. It drives `req_type` with all four codes, and its random masks include masks that hold only the local node. Ready is driven per port, sometimes at random and sometimes held low on a single port, so that independent draining is exercised while the other assumptions still hold.

// File: rtl/ring_hdr_pkg.sv
`timescale 1ns/1ps
package ring_hdr_pkg;

    typedef enum logic [1:0] {
        HT_UNI   = 2'b00,
        HT_MULTI = 2'b01,
        HT_BCAST = 2'b10,
        HT_RSVD  = 2'b11
    } hdr_type_e;

    localparam int PORTS = 4;

    localparam logic [1:0] BR_LEFT   = 2'd0;
    localparam logic [1:0] BR_XLEFT  = 2'd1;
    localparam logic [1:0] BR_XRIGHT = 2'd2;
    localparam logic [1:0] BR_RIGHT  = 2'd3;

    // (a + b) mod n for a, b already below n
    function automatic int wrap_add(int a, int b, int n);
        int s;
        s = a + b;
        if (s >= n) s = s - n;
        return s;
    endfunction

    // Relative offset of the node reached at hop index `hop` (0 = first hop) on branch `br`
    function automatic int hop_offset(int br, int hop, int n);
        case (br)
            0:       return hop + 1;
            1:       return n / 2 - hop;
            2:       return n / 2 + hop;
            default: return n - 1 - hop;
        endcase
    endfunction

endpackage

// File: rtl/ring_quadrant.sv
`timescale 1ns/1ps
module ring_quadrant
    import ring_hdr_pkg::*;
#(
    parameter  int NODES = 16,
    localparam int AW    = $clog2(NODES),
    localparam int QTR   = NODES / 4,
    localparam int HALF  = NODES / 2
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    output logic [1:0]    port_sel,
    output logic          is_self
);

    int offs;

    always_comb begin
        offs = int'(dst) - int'(src);
        if (offs < 0) offs = offs + NODES;
        is_self = (offs == 0);
        if (offs <= QTR)
            port_sel = BR_LEFT;
        else if (offs <= HALF)
            port_sel = BR_XLEFT;
        else if (offs < HALF + QTR)
            port_sel = BR_XRIGHT;
        else
            port_sel = BR_RIGHT;
    end

endmodule

// File: rtl/ring_branch_split.sv
`timescale 1ns/1ps
module ring_branch_split
    import ring_hdr_pkg::*;
#(
    parameter  int NODES = 16,
    localparam int AW    = $clog2(NODES),
    localparam int QTR   = NODES / 4
) (
    input  logic [AW-1:0]                src,
    input  logic [NODES-1:0]             mask,
    output logic [PORTS-1:0][QTR-1:0]    br_bits,
    output logic [PORTS-1:0][AW-1:0]     br_dest,
    output logic [PORTS-1:0]             br_any
);

    // Targets re-indexed by offset from the source; offset 0 (self) is dropped
    logic [NODES-1:1] rel;

    always_comb begin
        for (int j = 1; j < NODES; j++) begin
            rel[j] = mask[AW'(wrap_add(int'(src), j, NODES))];
        end
    end

    always_comb begin
        for (int b = 0; b < PORTS; b++) begin
            for (int k = 0; k < QTR; k++) begin
                if (b == 2 && k == 0)
                    br_bits[b][k] = 1'b0;   // chord end belongs to cross-left
                else
                    br_bits[b][k] = rel[AW'(hop_offset(b, k, NODES))];
            end
        end
    end

    always_comb begin
        int far;
        for (int b = 0; b < PORTS; b++) begin
            far = 0;
            for (int k = 0; k < QTR; k++) begin
                if (br_bits[b][k]) far = k;
            end
            br_dest[b] = AW'(wrap_add(int'(src), hop_offset(b, far, NODES), NODES));
            br_any[b]  = |br_bits[b];
        end
    end

endmodule

// File: rtl/ring_port_slot.sv
`timescale 1ns/1ps
module ring_port_slot #(
    parameter int FW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [FW-1:0] load_flit,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [FW-1:0] out_flit
);

    typedef struct packed {
        logic          vld;
        logic [FW-1:0] flit;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (slot_q.vld && out_ready) slot_d.vld = 1'b0;
        if (load) begin
            slot_d.vld  = 1'b1;
            slot_d.flit = load_flit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign out_valid = slot_q.vld;
    assign out_flit  = slot_q.flit;

endmodule

// File: rtl/ring_hdr_gen.sv
`timescale 1ns/1ps
module ring_hdr_gen
    import ring_hdr_pkg::*;
#(
    parameter  int NODES = 16,
    localparam int AW    = $clog2(NODES),
    localparam int QTR   = NODES / 4,
    localparam int FW    = 2 + AW + QTR
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [AW-1:0]         local_addr,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [1:0]            req_type,
    input  logic [AW-1:0]         req_dest,
    input  logic [NODES-1:0]      req_mask,
    output logic                  req_err,
    output logic [PORTS-1:0]      hdr_valid,
    input  logic [PORTS-1:0]      hdr_ready,
    output logic [PORTS*FW-1:0]   hdr_flit
);

    typedef struct packed {
        logic err;
    } gen_state_t;

    gen_state_t state_d, state_q;

    logic [1:0]                uc_port;
    logic                      uc_self;
    logic [PORTS-1:0][QTR-1:0] mc_bits;
    logic [PORTS-1:0][AW-1:0]  mc_dest;
    logic [PORTS-1:0]          mc_any;
    logic [PORTS-1:0][AW-1:0]  bc_dest;
    logic [PORTS-1:0]          load;
    logic [PORTS-1:0][FW-1:0]  ld_flit;
    logic [PORTS-1:0]          slot_vld;
    logic                      accept;
    logic                      bad;

    ring_quadrant #(.NODES(NODES)) u_quad (
        .src      (local_addr),
        .dst      (req_dest),
        .port_sel (uc_port),
        .is_self  (uc_self)
    );

    ring_branch_split #(.NODES(NODES)) u_split (
        .src     (local_addr),
        .mask    (req_mask),
        .br_bits (mc_bits),
        .br_dest (mc_dest),
        .br_any  (mc_any)
    );

    // Broadcast branch ends: last hop of each full branch
    always_comb begin
        for (int b = 0; b < PORTS; b++) begin
            bc_dest[b] = AW'(wrap_add(int'(local_addr), hop_offset(b, QTR - 1, NODES), NODES));
        end
    end

    always_comb begin
        state_d = state_q;
        load    = '0;
        ld_flit = '0;
        bad     = 1'b0;
        accept  = req_valid && req_ready;
        case (hdr_type_e'(req_type))
            HT_UNI: begin
                if (uc_self) begin
                    bad = 1'b1;
                end else begin
                    load[uc_port]    = 1'b1;
                    ld_flit[uc_port] = {HT_UNI, req_dest, {QTR{1'b0}}};
                end
            end
            HT_MULTI: begin
                if (!(|mc_any)) bad = 1'b1;
                for (int b = 0; b < PORTS; b++) begin
                    load[b]    = mc_any[b];
                    ld_flit[b] = {HT_MULTI, mc_dest[b], mc_bits[b]};
                end
            end
            HT_BCAST: begin
                for (int b = 0; b < PORTS; b++) begin
                    load[b]    = 1'b1;
                    ld_flit[b] = {HT_BCAST, bc_dest[b], {QTR{1'b0}}};
                end
            end
            default: bad = 1'b1;
        endcase
        load        = load & {PORTS{accept}};
        state_d.err = accept && bad;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_slot
        ring_port_slot #(.FW(FW)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (load[p]),
            .load_flit (ld_flit[p]),
            .out_ready (hdr_ready[p]),
            .out_valid (slot_vld[p]),
            .out_flit  (hdr_flit[p*FW +: FW])
        );
    end

    assign hdr_valid = slot_vld;
    assign req_ready = ~|slot_vld;
    assign req_err   = state_q.err;

endmodule

// File: rtl/ring_hdr_gen_chk.sv
`timescale 1ns/1ps
module ring_hdr_gen_chk #(
    parameter  int NODES = 16,
    localparam int AW    = $clog2(NODES),
    localparam int QTR   = NODES / 4,
    localparam int FW    = 2 + AW + QTR
) (
    input logic              clk,
    input logic              rst_n,
    input logic [AW-1:0]     local_addr,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_type,
    input logic [AW-1:0]     req_dest,
    input logic              req_err,
    input logic [3:0]        hdr_valid,
    input logic [3:0]        hdr_ready,
    input logic [4*FW-1:0]   hdr_flit
);

    logic take;
    assign take = req_valid && req_ready;

    AST_TAKE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n) take |=> ((|hdr_valid) != req_err)); // R2

    AST_UNI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) (take && req_type == 2'b00 && req_dest != local_addr) |=> ($countones(hdr_valid) == 1)); // R3

    AST_BCAST_ALL: assert property (@(posedge clk) disable iff (!rst_n) (take && req_type == 2'b10) |=> (hdr_valid == 4'hF)); // R4

    AST_SELF_DROP: assert property (@(posedge clk) disable iff (!rst_n) (take && req_type == 2'b00 && req_dest == local_addr) |=> (req_err && hdr_valid == 4'h0)); // R9

    AST_RSVD_DROP: assert property (@(posedge clk) disable iff (!rst_n) (take && req_type == 2'b11) |=> req_err); // R9

    for (genvar p = 0; p < 4; p++) begin : g_port
        AST_HOLD_FLIT: assert property (@(posedge clk) disable iff (!rst_n) (hdr_valid[p] && !hdr_ready[p]) |=> (hdr_valid[p] && $stable(hdr_flit[p*FW +: FW]))); // R8
        AST_DRAIN_PORT: assert property (@(posedge clk) disable iff (!rst_n) (hdr_valid[p] && hdr_ready[p]) |=> !hdr_valid[p]); // R8
        AST_TYPE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) hdr_valid[p] |-> (hdr_flit[p*FW + FW - 2 +: 2] != 2'b11)); // R7
    end

endmodule

bind ring_hdr_gen ring_hdr_gen_chk #(.NODES(NODES)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .local_addr (local_addr),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_type   (req_type),
    .req_dest   (req_dest),
    .req_err    (req_err),
    .hdr_valid  (hdr_valid),
    .hdr_ready  (hdr_ready),
    .hdr_flit   (hdr_flit)
);

// File: tb/test_ring_hdr_gen.sv
`timescale 1ns/1ps
module test_ring_hdr_gen;

    localparam int N  = 16;
    localparam int AW = $clog2(N);
    localparam int Q  = N / 4;
    localparam int FW = 2 + AW + Q;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [AW-1:0]     local_addr = '0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_type = '0;
    logic [AW-1:0]     req_dest = '0;
    logic [N-1:0]      req_mask = '0;
    logic              req_err;
    logic [3:0]        hdr_valid;
    logic [3:0]        hdr_ready = 4'hF;
    logic [4*FW-1:0]   hdr_flit;

    always #2 clk = ~clk;

    ring_hdr_gen #(.NODES(N)) i_ring_hdr_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .local_addr (local_addr),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_type   (req_type),
        .req_dest   (req_dest),
        .req_mask   (req_mask),
        .req_err    (req_err),
        .hdr_valid  (hdr_valid),
        .hdr_ready  (hdr_ready),
        .hdr_flit   (hdr_flit)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";
    logic [3:0] stall_mask = 4'h0;
    bit    rand_en = 1'b0;

    logic [FW-1:0] q0[$];
    logic [FW-1:0] q1[$];
    logic [FW-1:0] q2[$];
    logic [FW-1:0] q3[$];

    function automatic int wrapn(int v);
        return ((v % N) + N) % N;
    endfunction

    task automatic check(input bit ok, input string what, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    // Ready driver: changes 1 ns after the rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            hdr_ready = ~stall_mask & (rand_en ? 4'($urandom) : 4'hF);
        end
    end

    // Monitor: compares every completed handshake against the scoreboard
    always @(negedge clk) begin
        logic [FW-1:0] got;
        logic [FW-1:0] want;
        bit            empty;
        if (rst_n) begin
            for (int p = 0; p < 4; p++) begin
                if (hdr_valid[p] && hdr_ready[p]) begin
                    got   = hdr_flit[p*FW +: FW];
                    want  = '0;
                    empty = 1'b0;
                    case (p)
                        0: if (q0.size() == 0) empty = 1'b1; else want = q0.pop_front();
                        1: if (q1.size() == 0) empty = 1'b1; else want = q1.pop_front();
                        2: if (q2.size() == 0) empty = 1'b1; else want = q2.pop_front();
                        default: if (q3.size() == 0) empty = 1'b1; else want = q3.pop_front();
                    endcase
                    check(!empty && got == want,
                          $sformatf("%s/R7 header on port %0d", cur_tag, p), got, want);
                end
            end
        end
    end

    // Expected outcome computed from the requirements
    task automatic model(input logic [1:0] ty, input int dst, input logic [N-1:0] msk, input int src,
                         output logic [3:0] vmask, output bit err,
                         output logic [3:0][FW-1:0] f);
        logic [3:0][Q-1:0]  bb;
        logic [3:0][AW-1:0] dd;
        int far [4];
        int d, b, k, node;
        vmask = '0; err = 1'b0; f = '0; bb = '0; dd = '0;
        for (int i = 0; i < 4; i++) far[i] = -1;
        case (ty)
            2'b00: begin
                if (dst == src) err = 1'b1;
                else begin
                    d = wrapn(dst - src);
                    if (d <= Q)              b = 0;
                    else if (d <= N/2)       b = 1;
                    else if (d < N/2 + Q)    b = 2;
                    else                     b = 3;
                    vmask[b] = 1'b1;
                    f[b] = {2'b00, AW'(dst), Q'(0)};
                end
            end
            2'b01: begin
                for (int j = 1; j < N; j++) begin
                    node = wrapn(src + j);
                    if (msk[node]) begin
                        if (j <= Q)            begin b = 0; k = j - 1;     end
                        else if (j <= N/2)     begin b = 1; k = N/2 - j;   end
                        else if (j < N/2 + Q)  begin b = 2; k = j - N/2;   end
                        else                   begin b = 3; k = N - 1 - j; end
                        bb[b][k] = 1'b1;
                        if (k > far[b]) begin far[b] = k; dd[b] = AW'(node); end
                    end
                end
                for (int i = 0; i < 4; i++) begin
                    if (bb[i] != '0) begin
                        vmask[i] = 1'b1;
                        f[i] = {2'b01, dd[i], bb[i]};
                    end
                end
                if (vmask == '0) err = 1'b1;
            end
            2'b10: begin
                vmask = 4'hF;
                f[0] = {2'b10, AW'(wrapn(src + Q)),           Q'(0)};
                f[1] = {2'b10, AW'(wrapn(src + N/2 - Q + 1)), Q'(0)};
                f[2] = {2'b10, AW'(wrapn(src + N/2 + Q - 1)), Q'(0)};
                f[3] = {2'b10, AW'(wrapn(src - Q)),           Q'(0)};
            end
            default: err = 1'b1;
        endcase
    endtask

    // Driver: waits for idle, pushes expectations, offers one request
    task automatic send(input logic [1:0] ty, input int dst, input logic [N-1:0] msk,
                        input int src, input string tag);
        logic [3:0]         vmask;
        bit                 err;
        logic [3:0][FW-1:0] f;
        model(ty, dst, msk, src, vmask, err, f);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cur_tag = tag;
        if (vmask[0]) q0.push_back(f[0]);
        if (vmask[1]) q1.push_back(f[1]);
        if (vmask[2]) q2.push_back(f[2]);
        if (vmask[3]) q3.push_back(f[3]);
        @(posedge clk);
        #1;
        local_addr = AW'(src);
        req_type   = ty;
        req_dest   = AW'(dst);
        req_mask   = msk;
        req_valid  = 1'b1;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        req_dest  = AW'($urandom);
        req_mask  = N'($urandom);
        @(negedge clk);
        check(hdr_valid == vmask, $sformatf("%s/R2 ports loaded", tag), hdr_valid, vmask);
        check(req_err == err, $sformatf("%s/R9 error flag", tag), req_err, err);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL R2 watchdog actual=hung expected=drained");
            summary();
            $finish;
        end
    end

    initial begin
        logic [FW-1:0] held;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(hdr_valid == 4'h0, "R1 valid after reset", hdr_valid, 0);
        check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        check(req_err == 1'b0, "R1 error after reset", req_err, 0);

        // R4: broadcast from node 0, literal branch ends 4, 5, 11, 12
        send(2'b10, 0, '0, 0, "R4");
        check(hdr_flit[0*FW+Q +: AW] == 4, "R4 left end", hdr_flit[0*FW+Q +: AW], 4);
        check(hdr_flit[1*FW+Q +: AW] == 5, "R4 cross-left end", hdr_flit[1*FW+Q +: AW], 5);
        check(hdr_flit[2*FW+Q +: AW] == 11, "R4 cross-right end", hdr_flit[2*FW+Q +: AW], 11);
        check(hdr_flit[3*FW+Q +: AW] == 12, "R4 right end", hdr_flit[3*FW+Q +: AW], 12);
        send(2'b10, 0, '0, 7, "R4");
        send(2'b10, 0, '0, 13, "R4");

        // R3: every destination from two sources, self gives an error (R9)
        for (int d = 0; d < N; d++) send(2'b00, d, '0, 5, (d == 5) ? "R9" : "R3");
        rand_en = 1'b1;
        for (int d = 0; d < N; d++) send(2'b00, d, '0, 15, (d == 15) ? "R9" : "R3");

        // R5: single targets around node 6; the local bit alone is an error
        for (int j = 0; j < N; j++) send(2'b01, 0, N'(1) << j, 6, (j == 6) ? "R9" : "R5");
        send(2'b01, 0, {N{1'b1}}, 0, "R5");
        send(2'b01, 0, {N{1'b1}}, 11, "R5");

        // R6: random multicast sets from random sources
        for (int i = 0; i < 40; i++) send(2'b01, 0, N'($urandom), $urandom_range(0, N - 1), "R6");
        send(2'b01, 0, 16'h0010, 2, "R6");
        send(2'b01, 0, 16'h8001, 0, "R6");

        // R9: empty mask and reserved type
        send(2'b01, 3, '0, 4, "R9");
        send(2'b11, 1, 16'hFFFF, 9, "R9");

        // R10: unused fields carry garbage
        send(2'b00, 10, 16'hA5C3, 2, "R10");
        send(2'b10, 13, 16'h3C5A, 9, "R10");
        send(2'b01, 0, 16'h0F0F, 1, "R10");
        send(2'b01, 14, 16'h0F0F, 1, "R10");

        // R8: cross-right port stalled, others drain, stalled header holds
        rand_en = 1'b0;
        stall_mask = 4'b0100;
        send(2'b10, 0, '0, 3, "R8");
        held = hdr_flit[2*FW +: FW];
        repeat (3) @(negedge clk);
        check(hdr_valid == 4'b0100, "R8 others drained", hdr_valid, 4'b0100);
        check(req_ready == 1'b0, "R2 busy while a port holds", req_ready, 0);
        check(hdr_flit[2*FW +: FW] == held, "R8 stalled header stable", hdr_flit[2*FW +: FW], held);
        check(held == {2'b10, AW'(wrapn(3 + N/2 + Q - 1)), Q'(0)}, "R4 stalled cross-right header",
              held, {2'b10, AW'(wrapn(3 + N/2 + Q - 1)), Q'(0)});
        stall_mask = 4'b0000;
        send(2'b00, 4, '0, 3, "R8");

        @(negedge clk);
        while (q0.size() + q1.size() + q2.size() + q3.size() != 0 || hdr_valid != 0) @(negedge clk);
        check(req_ready == 1'b1, "R2 idle after drain", req_ready, 1);

        if (!done) begin
            done = 1'b1;
            summary();
            $finish;
        end
    end

endmodule